// File: doc/BRIEF.md
# FSK Proximity Tag Waveform Generator

This block produces the load-modulation pattern that a 125 kHz-class proximity credential sends back to a reader. The pattern uses frequency-shift keying: each sub-carrier cycle lasts either 8 or 10 reader carrier periods. A coil load switch follows the one-bit output, so a reader sees a tag carrying the 44-bit identifier applied at `id_i`. The carrier edge detector outside the block gives one strobe per rising edge of the reader field, and each strobe moves the waveform forward by one sample.

The frame is built from a chain of small counters, so no sample memory is needed. A phase counter walks one sub-carrier cycle. A repetition counter groups cycles into symbols. A segment sequencer steps through these parts in order:

- a lead-in cycle,
- an eight-symbol start marker that no valid data bit can produce,
- the Manchester-coded identifier bits, with a short marker cycle placed ahead of every group of four bits.

While enabled, the frame repeats without a gap. Deasserting the enable opens the coil and rewinds the frame. The identifier is captured only at frame boundaries, so a frame never mixes two IDs.

Top module: `lf_fsk_tag_emulator`

## Requirements
- R1: A divide-by-8 cycle presents the eight samples 1,1,0,0,0,0,0,0 in that order. A divide-by-8 symbol is six such cycles (48 samples).
- R2: A divide-by-10 cycle presents the ten samples 1,1,1,0,0,0,0,0,0,0. A divide-by-10 symbol is five such cycles (50 samples).
- R3: An ID bit of value 1 is sent as a divide-by-10 symbol then a divide-by-8 symbol. A 0 is sent as divide-by-8 then divide-by-10. Frame sample 410 (third sample of the first data symbol) therefore equals ID bit 43.
- R4: Every frame opens with one lone divide-by-8 cycle (samples 0..7). The start marker follows at samples 8..399 as the symbol kinds 8,8,8,10,10,10,8,10.
- R5: ID bits go out from bit 43 down to bit 0. A lone divide-by-8 cycle comes before each bit whose index modulo 4 equals 3, so one frame is 4800 samples.
- R6: Each clock with both enable and strobe high advances exactly one sample. With no strobe, the output holds. After the last sample, the frame restarts at sample 0.
- R7: With enable low, or during synchronous reset, `coil_open_o` is 1 (coil open) and `frame_start_o` is 0. The sequencer sits at sample 0, so the first sample after enable rises is sample 0.
- R8: While disabled, the ID register follows `id_i`. While enabled, it reloads only on the strobe that wraps the frame, so a change of `id_i` mid-frame first shows in the next frame.
- R9: `frame_start_o` is 1 exactly while sample 0 of a frame is presented with enable high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Run the emulation; low forces coil open and rewinds |
| strobe_i | input | 1 | One-clock pulse per reader carrier rising edge |
| id_i | input | ID_W | Identifier to transmit, bit 43 sent first |
| coil_open_o | output | 1 | 1 = coil open, 0 = coil shorted |
| frame_start_o | output | 1 | High while sample 0 of a frame is presented |

## Verification
The hardest situations to reach are an ID change, or a drop of enable, deep inside a frame. At those points the sequencer is in the data field, partway through both a symbol and a cycle. The stimulus counts exact strobe numbers to stop at sample 2000 or sample 1000. At that point it either swaps `id_i` and captures the rest of that frame plus the whole next one, or drops enable with strobes still pulsing. Holding the strobe low for many clocks mid-symbol, and spacing strobes with idle clocks, shows that only strobes move the waveform.

// File: rtl/lf_fsk_pkg.sv
package lf_fsk_pkg;

    localparam int ID_BITS      = 44;
    localparam int GROUP_BITS   = 4;
    localparam int FC8_PERIOD   = 8;
    localparam int FC8_HIGH     = 2;
    localparam int FC8_REPS     = 6;
    localparam int FC10_PERIOD  = 10;
    localparam int FC10_HIGH    = 3;
    localparam int FC10_REPS    = 5;
    localparam int SOF_SYMS     = 8;
    // bit i set: start-marker symbol i uses the divide-by-10 cycle
    localparam logic [SOF_SYMS-1:0] SOF_FC10_MASK = 8'b1011_1000;

    typedef enum logic [1:0] {
        SEG_LEAD  = 2'd0,
        SEG_SOF   = 2'd1,
        SEG_GMARK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_e;

    typedef struct packed {
        logic is_fc10;   // cycle length 10 instead of 8
        logic single;    // symbol is one lone cycle
    } sym_shape_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lf_fsk_cycle_gen.sv
module lf_fsk_cycle_gen
    import lf_fsk_pkg::*;
#(
    parameter int P8  = FC8_PERIOD,
    parameter int H8  = FC8_HIGH,
    parameter int P10 = FC10_PERIOD,
    parameter int H10 = FC10_HIGH
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    input  logic step_i,
    input  logic is_fc10_i,
    output logic level_o,
    output logic cyc_end_o,
    output logic at_zero_o
);
    localparam int PMAX = max2(P8, P10);
    localparam int PH_W = $clog2(PMAX + 1);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] last_idx;
    logic [PH_W-1:0] high_cnt;

    always_comb begin
        last_idx = is_fc10_i ? PH_W'(P10 - 1) : PH_W'(P8 - 1);
        high_cnt = is_fc10_i ? PH_W'(H10) : PH_W'(H8);
    end

    assign cyc_end_o = (phase_q == last_idx);
    assign level_o   = (phase_q < high_cnt);
    assign at_zero_o = (phase_q == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            phase_q <= '0;
        end else if (step_i) begin
            phase_q <= cyc_end_o ? '0 : phase_q + PH_W'(1);
        end
    end

endmodule

// File: rtl/lf_fsk_symbol_ctr.sv
module lf_fsk_symbol_ctr
    import lf_fsk_pkg::*;
#(
    parameter int R8  = FC8_REPS,
    parameter int R10 = FC10_REPS
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       restart_i,
    input  logic       step_i,
    input  logic       cyc_end_i,
    input  sym_shape_t shape_i,
    output logic       sym_end_o
);
    localparam int CNT_W = $clog2(max2(R8, R10) + 1);

    logic [CNT_W-1:0] rep_q;
    logic [CNT_W-1:0] rep_last;

    always_comb begin
        if (shape_i.single) begin
            rep_last = '0;
        end else if (shape_i.is_fc10) begin
            rep_last = CNT_W'(R10 - 1);
        end else begin
            rep_last = CNT_W'(R8 - 1);
        end
    end

    assign sym_end_o = cyc_end_i && (rep_q == rep_last);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            rep_q <= '0;
        end else if (step_i && cyc_end_i) begin
            rep_q <= sym_end_o ? '0 : rep_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lf_fsk_frame_seq.sv
module lf_fsk_frame_seq
    import lf_fsk_pkg::*;
#(
    parameter int                  ID_W     = ID_BITS,
    parameter int                  GROUP_W  = GROUP_BITS,
    parameter int                  SOF_N    = SOF_SYMS,
    parameter logic [SOF_N-1:0]    SOF_MASK = SOF_FC10_MASK
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            restart_i,
    input  logic            sym_step_i,
    input  logic [ID_W-1:0] id_i,
    output sym_shape_t      shape_o,
    output logic            at_lead_o,
    output logic            last_sym_o
);
    localparam int BIT_W = $clog2(ID_W);
    localparam int SOF_W = $clog2(SOF_N);

    seg_e             seg_q;
    logic [SOF_W-1:0] sof_q;
    logic [BIT_W-1:0] bit_q;
    logic             half_q;
    logic [BIT_W-1:0] bit_dn;

    function automatic logic opens_group(input logic [BIT_W-1:0] b);
        return (int'(b) % GROUP_W) == (GROUP_W - 1);
    endfunction

    assign bit_dn = bit_q - BIT_W'(1);

    always_comb begin
        shape_o = '{is_fc10: 1'b0, single: 1'b1};
        case (seg_q)
            SEG_SOF:  shape_o = '{is_fc10: SOF_MASK[sof_q], single: 1'b0};
            SEG_DATA: shape_o = '{is_fc10: id_i[bit_q] ^ half_q, single: 1'b0};
            default:  shape_o = '{is_fc10: 1'b0, single: 1'b1};
        endcase
    end

    assign at_lead_o  = (seg_q == SEG_LEAD);
    assign last_sym_o = (seg_q == SEG_DATA) && (bit_q == '0) && half_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            seg_q  <= SEG_LEAD;
            sof_q  <= '0;
            bit_q  <= BIT_W'(ID_W - 1);
            half_q <= 1'b0;
        end else if (sym_step_i) begin
            case (seg_q)
                SEG_LEAD: begin
                    seg_q <= SEG_SOF;
                    sof_q <= '0;
                end
                SEG_SOF: begin
                    if (sof_q == SOF_W'(SOF_N - 1)) begin
                        bit_q  <= BIT_W'(ID_W - 1);
                        half_q <= 1'b0;
                        seg_q  <= opens_group(BIT_W'(ID_W - 1)) ? SEG_GMARK : SEG_DATA;
                    end else begin
                        sof_q <= sof_q + SOF_W'(1);
                    end
                end
                SEG_GMARK: begin
                    seg_q  <= SEG_DATA;
                    half_q <= 1'b0;
                end
                default: begin
                    if (!half_q) begin
                        half_q <= 1'b1;
                    end else if (bit_q == '0) begin
                        seg_q  <= SEG_LEAD;
                        half_q <= 1'b0;
                        bit_q  <= BIT_W'(ID_W - 1);
                    end else begin
                        half_q <= 1'b0;
                        bit_q  <= bit_dn;
                        seg_q  <= opens_group(bit_dn) ? SEG_GMARK : SEG_DATA;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/lf_fsk_tag_emulator.sv
module lf_fsk_tag_emulator
    import lf_fsk_pkg::*;
#(
    parameter int ID_W        = ID_BITS,
    parameter int GROUP_W     = GROUP_BITS,
    parameter int FC8_P       = FC8_PERIOD,
    parameter int FC8_H       = FC8_HIGH,
    parameter int FC8_R       = FC8_REPS,
    parameter int FC10_P      = FC10_PERIOD,
    parameter int FC10_H      = FC10_HIGH,
    parameter int FC10_R      = FC10_REPS
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            enable_i,
    input  logic            strobe_i,
    input  logic [ID_W-1:0] id_i,
    output logic            coil_open_o,
    output logic            frame_start_o
);
    logic            step;
    logic            restart;
    logic [ID_W-1:0] id_q;
    sym_shape_t      shape;
    logic            level;
    logic            cyc_end;
    logic            phase_zero;
    logic            sym_end;
    logic            at_lead;
    logic            last_sym;
    logic            frame_wrap;

    assign step       = enable_i && strobe_i;
    assign restart    = !enable_i;
    assign frame_wrap = step && sym_end && last_sym;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            id_q <= '0;
        end else if (restart || frame_wrap) begin
            id_q <= id_i;
        end
    end

    lf_fsk_cycle_gen #(
        .P8 (FC8_P),
        .H8 (FC8_H),
        .P10(FC10_P),
        .H10(FC10_H)
    ) cyc_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .restart_i(restart),
        .step_i   (step),
        .is_fc10_i(shape.is_fc10),
        .level_o  (level),
        .cyc_end_o(cyc_end),
        .at_zero_o(phase_zero)
    );

    lf_fsk_symbol_ctr #(
        .R8 (FC8_R),
        .R10(FC10_R)
    ) sym_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .restart_i(restart),
        .step_i   (step),
        .cyc_end_i(cyc_end),
        .shape_i  (shape),
        .sym_end_o(sym_end)
    );

    lf_fsk_frame_seq #(
        .ID_W   (ID_W),
        .GROUP_W(GROUP_W)
    ) seq_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (restart),
        .sym_step_i(step && sym_end),
        .id_i      (id_q),
        .shape_o   (shape),
        .at_lead_o (at_lead),
        .last_sym_o(last_sym)
    );

    assign coil_open_o   = !enable_i || rst_i || level;
    assign frame_start_o = enable_i && !rst_i && at_lead && phase_zero;

endmodule

// File: rtl/lf_fsk_tag_emulator_chk.sv
module lf_fsk_tag_emulator_chk #(
    parameter int ID_W = 44
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            enable_i,
    input logic            strobe_i,
    input logic            coil_open_o,
    input logic            frame_start_o,
    input logic [ID_W-1:0] id_q,
    input logic            frame_wrap
);

    AST_DISABLED_OPEN: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |-> (coil_open_o && !frame_start_o)); // R7

    AST_REWIND_ON_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |=> (!enable_i || frame_start_o)); // R7

    AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        (enable_i && !strobe_i) |=> (!enable_i || $stable(coil_open_o))); // R6

    AST_WRAP_TO_START: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_wrap |=> (!enable_i || frame_start_o)); // R6

    AST_START_SAMPLE_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start_o |-> (coil_open_o && enable_i)); // R9

    AST_ID_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (enable_i && !frame_wrap) |=> $stable(id_q)); // R8

endmodule

bind lf_fsk_tag_emulator lf_fsk_tag_emulator_chk #(.ID_W(ID_W)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .enable_i     (enable_i),
    .strobe_i     (strobe_i),
    .coil_open_o  (coil_open_o),
    .frame_start_o(frame_start_o),
    .id_q         (id_q),
    .frame_wrap   (frame_wrap)
);

// File: tb/lf_fsk_tag_emulator_tb.sv
module lf_fsk_tag_emulator_tb_top;

    localparam int IDW   = 44;
    localparam int FRAME = 4800;

    // {expected sample 410, id}
    localparam logic [IDW:0] VEC [5] = '{
        {1'b0, 44'h000_0000_0000},
        {1'b1, 44'hFFF_FFFF_FFFF},
        {1'b1, 44'hA5A_5A5A_5A5A},
        {1'b0, 44'h123_4567_89AB},
        {1'b1, 44'h800_0000_0001}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           enable = 1'b0;
    logic           strobe = 1'b0;
    logic [IDW-1:0] id = '0;
    logic           coil;
    logic           fs;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    int  exp_n;
    bit  exp_w  [FRAME];
    bit  cap_w  [FRAME];
    bit  cap_fs [FRAME];

    always #2 clk = ~clk;

    lf_fsk_tag_emulator dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .enable_i     (enable),
        .strobe_i     (strobe),
        .id_i         (id),
        .coil_open_o  (coil),
        .frame_start_o(fs)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push_cycle(input bit is10);
        int per = is10 ? 10 : 8;
        int hi  = is10 ? 3 : 2;
        for (int p = 0; p < per; p++) begin
            if (exp_n < FRAME) exp_w[exp_n] = (p < hi);
            exp_n++;
        end
    endtask

    task automatic push_symbol(input bit is10);
        int reps = is10 ? 5 : 6;
        for (int r = 0; r < reps; r++) push_cycle(is10);
    endtask

    task automatic build(input logic [IDW-1:0] v);
        bit sofp [8] = '{0, 0, 0, 1, 1, 1, 0, 1};
        exp_n = 0;
        push_cycle(1'b0);
        for (int s = 0; s < 8; s++) push_symbol(sofp[s]);
        for (int i = IDW - 1; i >= 0; i--) begin
            if ((i % 4) == 3) push_cycle(1'b0);
            if (v[i]) begin
                push_symbol(1'b1);
                push_symbol(1'b0);
            end else begin
                push_symbol(1'b0);
                push_symbol(1'b1);
            end
        end
    endtask

    // called at a negedge; leaves at a negedge
    task automatic run(input int first, input int count, input int gap);
        for (int k = 0; k < count; k++) begin
            #1;
            cap_w[first + k]  = coil;
            cap_fs[first + k] = fs;
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic cmp(input int lo, input int hi, input string req, input string what);
        int bad = 0;
        int first = lo;
        for (int k = lo; k <= hi; k++) begin
            if (cap_w[k] != exp_w[k]) begin
                if (bad == 0) first = k;
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("%s (%0d bad, first at sample %0d)", what, bad, first),
              int'(cap_w[first]), int'(exp_w[first]));
    endtask

    task automatic fs_once(input string what);
        int cnt = 0;
        for (int k = 0; k < FRAME; k++) cnt += int'(cap_fs[k]);
        check(cnt == 1 && cap_fs[0], "R9", what, cnt, 1);
    endtask

    task automatic start(input logic [IDW-1:0] v);
        @(negedge clk);
        enable = 1'b0;
        id = v;
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        enable = 1'b1;
        #1;
        check(coil == 1'b1, "R7", "coil open during reset", int'(coil), 1);
        check(fs == 1'b0, "R7", "no frame start during reset", int'(fs), 0);
        @(negedge clk);
        enable = 1'b0;
        rst = 1'b0;
        #1;
        check(coil == 1'b1, "R7", "coil open while disabled", int'(coil), 1);

        // table of vectors
        for (int v = 0; v < 5; v++) begin
            start(VEC[v][IDW-1:0]);
            build(VEC[v][IDW-1:0]);
            run(0, FRAME, v % 2);
            cmp(0, 7, "R4", "lead-in cycle");
            cmp(8, 55, "R1", "first divide-by-8 symbol");
            cmp(152, 201, "R2", "first divide-by-10 symbol");
            cmp(8, 399, "R4", "start marker");
            cmp(400, FRAME - 1, "R5", "identifier field");
            check(cap_w[410] == VEC[v][IDW], "R3", "sample 410 follows bit 43",
                  int'(cap_w[410]), int'(VEC[v][IDW]));
            fs_once("frame start once per frame");
            #1;
            check(fs == 1'b1 && coil == 1'b1, "R6", "wrap to sample 0 after 4800 strobes",
                  int'(fs), 1);
        end

        // strobe gaps: output holds
        begin
            int bad = 0;
            start(44'h3C3_C3C3_C3C3);
            build(44'h3C3_C3C3_C3C3);
            run(0, 30, 0);
            for (int c = 0; c < 20; c++) begin
                #1;
                if (coil != exp_w[30] || fs) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R6", "hold without strobe at sample 30", bad, 0);
            run(30, 40, 0);
            cmp(0, 69, "R6", "resume after hold");
        end

        // mid-frame ID change
        start(44'h0F0_0F0F_F0F0);
        build(44'h0F0_0F0F_F0F0);
        run(0, 2000, 0);
        id = 44'hFED_CBA9_8765;
        run(2000, FRAME - 2000, 0);
        cmp(0, FRAME - 1, "R8", "frame keeps ID latched at its start");
        build(44'hFED_CBA9_8765);
        run(0, FRAME, 0);
        cmp(0, FRAME - 1, "R8", "next frame carries new ID");

        // disable mid-frame
        begin
            int bad = 0;
            run(0, 1000, 0);
            enable = 1'b0;
            id = 44'h555_AAAA_5555;
            strobe = 1'b1;
            for (int c = 0; c < 10; c++) begin
                #1;
                if (!coil || fs) bad++;
                @(negedge clk);
            end
            strobe = 1'b0;
            check(bad == 0, "R7", "disabled with strobes: coil open, no start", bad, 0);
            enable = 1'b1;
            build(44'h555_AAAA_5555);
            run(0, FRAME, 1);
            cmp(0, FRAME - 1, "R7", "restart from sample 0 with ID taken while disabled");
            check(cap_fs[0] == 1'b1, "R9", "start flag on re-enable", int'(cap_fs[0]), 1);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog expired: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule